// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Word Loader

This block programs the configuration register of an asynchronous pseudo-SRAM. A caller presents the desired settings (page-mode read enable, refresh temperature range, sleep-mode select and partial-array range) together with the current case-temperature class and a method select, then pulses `start`. The loader packs the settings into a configuration word, checks that the requested refresh range is not colder than the case class, and drives the memory pins through one of two load sequences. One sequence frames a single write with the sleep pin held low and carries the word on the address lines. The other is an unlock pattern of four accesses to the all-ones address, with the word on the data bus in the last write. `done` pulses for one cycle when the sequence ends.

The memory pins are shared with a normal access controller. The loader drives them only while `grant` is high. With `grant` low it returns every pin to its idle level and its sequence waits. After a rejected request it pulses `done` with `reject` high and never touches the bus.

States: `ST_IDLE` (waits for `start`), `ST_ZZ_LEAD` (sleep pin low, chip enable high), `ST_ZZ_WR` (sleep pin low, write strobe active), `ST_ZZ_TAIL` (sleep pin low after the write ends), `ST_SW_GAP` (chip enable high before an unlock access), `ST_SW_ACC` (one unlock access), `ST_DONE` (one-cycle completion). Transitions: `ST_IDLE`→`ST_DONE` when the request is rejected; `ST_IDLE`→`ST_ZZ_LEAD` when `use_sw`=0; `ST_IDLE`→`ST_SW_GAP` when `use_sw`=1; `ST_ZZ_LEAD`→`ST_ZZ_WR`→`ST_ZZ_TAIL`→`ST_DONE`; `ST_SW_GAP`→`ST_SW_ACC`; `ST_SW_ACC`→`ST_SW_GAP` after accesses 0 to 2; `ST_SW_ACC`→`ST_DONE` after access 3; `ST_DONE`→`ST_IDLE`. The timed states step only in cycles with `grant` high, and they leave once their cycle count runs out.

Top module: `psram_cfg_loader`

## Requirements
- R1: The configuration word is 20 bits wide. Bit 7 is `page_en`, bits 6:5 are the refresh code, bit 4 is the sleep-mode bit and bits 2:0 are `array_sel` (000 is the full array, 100 is none of it). Bit 3 and bits 19:8 are always 0.
- R2: The refresh code is derived from `temp_sel` as follows. 3 (+85 C) gives 00, 2 (+70 C) gives 01, 1 (+45 C) gives 10 and 0 (+15 C) gives 11.
- R3: A request with `temp_sel` < `case_temp` is rejected. The loader enters `ST_DONE` at the accepting edge, so `done`=1 and `reject`=1 in the next cycle, and no pin leaves its idle level. `reject` holds until the next accepted `start`, and an accepted request clears it.
- R4: With `use_sw`=0 the sequence is as follows, and the address lines carry the word throughout. `mem_sleep_n`=0 with chip enable high for LEAD_CYC cycles. Then `mem_ce_n`=`mem_we_n`=0, `mem_oe_n`=1, `mem_bsel_n`=11 and no data drive for ACC_CYC cycles. Then `mem_sleep_n`=0 with chip enable high for HOLD_CYC cycles. Then `done`.
- R5: `mem_sleep_n` never stays low for more than MAX_ZZ_CYC consecutive cycles.
- R6: With `use_sw`=1 there are four accesses to address FFFFFh. Each one is preceded by GAP_CYC cycles with chip enable high and lasts ACC_CYC cycles with `mem_bsel_n`=00. The first two are reads (`mem_oe_n`=0). The third is a write of 0000h and the fourth is a write of the word's low 16 bits. `mem_sleep_n` stays 1.
- R7: With `use_sw`=1 word bit 4 is forced to 1. With `use_sw`=0 it equals `sleep_par`.
- R8: While `grant`=0 all pins are idle and the sequence holds its place. Idle means `mem_ce_n`=`mem_we_n`=`mem_oe_n`=`mem_sleep_n`=1, `mem_bsel_n`=11, `mem_dq_oe`=0, and `mem_addr` and `mem_dq_out` are 0. The sequence resumes where it stopped when `grant` returns.
- R9: `done` is a one-cycle pulse in the last cycle of a load. `busy` is high from the cycle after the accepting edge through the `done` cycle. A `start` while `busy` is ignored.
- R10: After reset the pins are idle and `busy`, `done` and `reject` are 0.
- R11: `mem_oe_n` and `mem_we_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a load (sampled in `ST_IDLE`) |
| use_sw | input | 1 | 0: sleep-pin method, 1: unlock-pattern method |
| page_en | input | 1 | Page-mode read enable setting |
| temp_sel | input | 2 | Requested refresh range, 0..3 = +15/+45/+70/+85 C |
| sleep_par | input | 1 | Sleep-mode select, 1 partial-array, 0 deep power-down |
| array_sel | input | 3 | Partial-array range code |
| case_temp | input | 2 | Case-temperature class, same scale as `temp_sel` |
| grant | input | 1 | Bus granted to the loader |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | Last request refused for too cold a refresh range |
| mem_addr | output | 20 | Memory address lines |
| mem_dq_out | output | 16 | Memory data to drive |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bsel_n | output | 2 | Byte selects, active low |
| mem_sleep_n | output | 1 | Sleep pin, active low |

## Verification
A wrong state or step index shows up at the pins in the very next cycle. Chip enable falls early or late, a read appears where a write belongs, or the sleep pin rises in the middle of a load. A stale or mis-packed word shows on the address or data lines during the first write cycle that carries it. A counter that keeps running while `grant` is low shifts every later cycle of the trace, so the per-cycle comparison against a queue of expected pin states catches it within one access length. A rejected request that leaks onto the bus breaks the idle expectation in the cycle after `start`.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZZ_LEAD,
        ST_ZZ_WR,
        ST_ZZ_TAIL,
        ST_SW_GAP,
        ST_SW_ACC,
        ST_DONE
    } seq_state_e;

    localparam int SW_STEPS = 4;

endpackage

// File: rtl/psram_cfg_pack.sv
module psram_cfg_pack #(
    parameter int ADDR_W = 20
) (
    input  logic              page_en,
    input  logic [1:0]        temp_sel,
    input  logic              sleep_par,
    input  logic [2:0]        array_sel,
    input  logic [1:0]        case_temp,
    input  logic              use_sw,
    output logic [ADDR_W-1:0] word,
    output logic              too_cold
);
    localparam int UPPER_W = ADDR_W - 8;

    logic [1:0] tcode;
    logic       sleep_bit;

    // R2: refresh code, warmest range maps to 00
    always_comb begin
        unique case (temp_sel)
            2'd3:    tcode = 2'b00;
            2'd2:    tcode = 2'b01;
            2'd1:    tcode = 2'b10;
            default: tcode = 2'b11;
        endcase
    end

    // R7: unlock pattern may never select deep power-down
    assign sleep_bit = use_sw ? 1'b1 : sleep_par;

    // R1: field layout, reserved bits zero
    assign word     = {{UPPER_W{1'b0}}, page_en, tcode, sleep_bit, 1'b0, array_sel};
    // R3: refresh range colder than the case class corrupts data
    assign too_cold = (temp_sel < case_temp);

endmodule

// File: rtl/psram_cfg_fsm.sv
module psram_cfg_fsm
    import psram_cfg_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int ACC_CYC  = 4,
    parameter int GAP_CYC  = 2,
    parameter int LEAD_CYC = 2,
    parameter int HOLD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_sw,
    input  logic              grant,
    input  logic [ADDR_W-1:0] word_in,
    input  logic              too_cold,
    output seq_state_e        state,
    output logic [1:0]        sw_idx,
    output logic [ADDR_W-1:0] word_q,
    output logic              busy,
    output logic              done,
    output logic              reject
);
    localparam int MAX_A = (ACC_CYC > GAP_CYC) ? ACC_CYC : GAP_CYC;
    localparam int MAX_B = (LEAD_CYC > HOLD_CYC) ? LEAD_CYC : HOLD_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LD_ACC  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP  = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_LEAD = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(HOLD_CYC - 1);
    localparam logic [1:0]       LAST_IDX = 2'(SW_STEPS - 1);

    seq_state_e       nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [1:0]       nxt_idx;
    logic             expired;

    assign expired = grant && (cnt == '0);

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_idx   = sw_idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt_idx = '0;
                    if (too_cold) begin
                        nxt_state = ST_DONE;
                    end else if (use_sw) begin
                        nxt_state = ST_SW_GAP;
                        nxt_cnt   = LD_GAP;
                    end else begin
                        nxt_state = ST_ZZ_LEAD;
                        nxt_cnt   = LD_LEAD;
                    end
                end
            end
            ST_ZZ_LEAD: begin
                if (expired) begin
                    nxt_state = ST_ZZ_WR;
                    nxt_cnt   = LD_ACC;
                end
            end
            ST_ZZ_WR: begin
                if (expired) begin
                    nxt_state = ST_ZZ_TAIL;
                    nxt_cnt   = LD_HOLD;
                end
            end
            ST_ZZ_TAIL: begin
                if (expired) nxt_state = ST_DONE;
            end
            ST_SW_GAP: begin
                if (expired) begin
                    nxt_state = ST_SW_ACC;
                    nxt_cnt   = LD_ACC;
                end
            end
            ST_SW_ACC: begin
                if (expired) begin
                    if (sw_idx == LAST_IDX) begin
                        nxt_state = ST_DONE;
                    end else begin
                        nxt_state = ST_SW_GAP;
                        nxt_cnt   = LD_GAP;
                        nxt_idx   = sw_idx + 2'd1;
                    end
                end
            end
            ST_DONE: nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
        if (grant && (cnt != '0) && (state != ST_IDLE) && (state != ST_DONE)) begin
            nxt_cnt = cnt - 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sw_idx <= '0;
            word_q <= '0;
            reject <= 1'b0;
        end else begin
            state  <= nxt_state;
            cnt    <= nxt_cnt;
            sw_idx <= nxt_idx;
            if (state == ST_IDLE && start) begin
                word_q <= word_in;
                reject <= too_cold;
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: no progress in timed states while the bus is withdrawn
    p_hold_on_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant && busy && !done) |=> ($stable(cnt) && $stable(sw_idx) && $stable(state)));

    // R3: a rejected load goes straight to completion
    p_reject_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && too_cold) |=> (done && reject));

endmodule

// File: rtl/psram_cfg_pins.sv
module psram_cfg_pins
    import psram_cfg_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int MAX_ZZ_CYC = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic [1:0]        sw_idx,
    input  logic [ADDR_W-1:0] word_q,
    input  logic              grant,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [1:0]        mem_bsel_n,
    output logic              mem_sleep_n
);
    localparam int ZZ_W = $clog2(MAX_ZZ_CYC + 2);
    localparam logic [ZZ_W-1:0] ZZ_SAT = {ZZ_W{1'b1}};

    always_comb begin
        mem_addr    = '0;
        mem_dq_out  = '0;
        mem_dq_oe   = 1'b0;
        mem_ce_n    = 1'b1;
        mem_we_n    = 1'b1;
        mem_oe_n    = 1'b1;
        mem_bsel_n  = 2'b11;
        mem_sleep_n = 1'b1;
        if (grant) begin
            unique case (state)
                ST_ZZ_LEAD, ST_ZZ_TAIL: begin
                    mem_sleep_n = 1'b0;
                    mem_addr    = word_q;
                end
                ST_ZZ_WR: begin
                    mem_sleep_n = 1'b0;
                    mem_addr    = word_q;
                    mem_ce_n    = 1'b0;
                    mem_we_n    = 1'b0;
                end
                ST_SW_GAP: begin
                    mem_addr = '1;
                end
                ST_SW_ACC: begin
                    mem_addr   = '1;
                    mem_ce_n   = 1'b0;
                    mem_bsel_n = 2'b00;
                    if (sw_idx[1] == 1'b0) begin
                        mem_oe_n = 1'b0;
                    end else begin
                        mem_we_n   = 1'b0;
                        mem_dq_oe  = 1'b1;
                        mem_dq_out = sw_idx[0] ? word_q[DATA_W-1:0] : '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // run length of the sleep pin held low
    logic [ZZ_W-1:0] zz_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            zz_run <= '0;
        else if (mem_sleep_n)  zz_run <= '0;
        else if (zz_run != ZZ_SAT) zz_run <= zz_run + 1'b1;
    end

    // R5: sleep pin framing stays inside its window
    p_zz_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        zz_run <= ZZ_W'(MAX_ZZ_CYC));

    // R8: pins idle whenever the bus is not granted
    p_idle_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (mem_ce_n && mem_sleep_n && !mem_dq_oe && mem_we_n));

    // R11: never read and write strobes together
    p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R7: a data-carried word always keeps partial-array sleep
    p_sw_no_dpd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && mem_dq_out != '0) |-> mem_dq_out[4]);

    // R1: reserved bits zero on the address-carried word
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sleep_n && !mem_we_n) |-> (mem_addr[ADDR_W-1:8] == '0 && !mem_addr[3]));

endmodule

// File: rtl/psram_cfg_loader.sv
module psram_cfg_loader
    import psram_cfg_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int ACC_CYC    = 4,
    parameter int GAP_CYC    = 2,
    parameter int LEAD_CYC   = 2,
    parameter int HOLD_CYC   = 1,
    parameter int MAX_ZZ_CYC = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_sw,
    input  logic              page_en,
    input  logic [1:0]        temp_sel,
    input  logic              sleep_par,
    input  logic [2:0]        array_sel,
    input  logic [1:0]        case_temp,
    input  logic              grant,
    output logic              busy,
    output logic              done,
    output logic              reject,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [1:0]        mem_bsel_n,
    output logic              mem_sleep_n
);
    logic [ADDR_W-1:0] word_c, word_q;
    logic              too_cold;
    seq_state_e        state;
    logic [1:0]        sw_idx;

    psram_cfg_pack #(.ADDR_W(ADDR_W)) u_pack (
        .page_en  (page_en),
        .temp_sel (temp_sel),
        .sleep_par(sleep_par),
        .array_sel(array_sel),
        .case_temp(case_temp),
        .use_sw   (use_sw),
        .word     (word_c),
        .too_cold (too_cold)
    );

    psram_cfg_fsm #(
        .ADDR_W  (ADDR_W),
        .ACC_CYC (ACC_CYC),
        .GAP_CYC (GAP_CYC),
        .LEAD_CYC(LEAD_CYC),
        .HOLD_CYC(HOLD_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .use_sw  (use_sw),
        .grant   (grant),
        .word_in (word_c),
        .too_cold(too_cold),
        .state   (state),
        .sw_idx  (sw_idx),
        .word_q  (word_q),
        .busy    (busy),
        .done    (done),
        .reject  (reject)
    );

    psram_cfg_pins #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MAX_ZZ_CYC(MAX_ZZ_CYC)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .sw_idx     (sw_idx),
        .word_q     (word_q),
        .grant      (grant),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_bsel_n (mem_bsel_n),
        .mem_sleep_n(mem_sleep_n)
    );

endmodule

// File: tb/psram_cfg_loader_tb_top.sv
module psram_cfg_loader_tb_top;
    localparam int ACC  = 4;
    localparam int GAP  = 2;
    localparam int LEAD = 2;
    localparam int HOLD = 1;
    localparam int MAXZ = 62;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, use_sw = 0, page_en = 0, sleep_par = 0, grant = 1;
    logic [1:0] temp_sel = 0, case_temp = 0;
    logic [2:0] array_sel = 0;
    logic busy, done, reject, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n, mem_sleep_n;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [1:0]  mem_bsel_n;

    always #4 clk = ~clk;

    psram_cfg_loader #(.ACC_CYC(ACC), .GAP_CYC(GAP), .LEAD_CYC(LEAD),
                       .HOLD_CYC(HOLD), .MAX_ZZ_CYC(MAXZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .use_sw(use_sw), .page_en(page_en),
        .temp_sel(temp_sel), .sleep_par(sleep_par), .array_sel(array_sel),
        .case_temp(case_temp), .grant(grant), .busy(busy), .done(done), .reject(reject),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_bsel_n(mem_bsel_n), .mem_sleep_n(mem_sleep_n));

    // vector: ce we oe zz dqoe bsel[2] addr[20] dq[16] done
    typedef logic [43:0] vec_t;
    vec_t  exp_q[$];
    string tag_q[$];
    logic  exp_reject = 0;
    int    n_checks = 0, n_fail = 0, cycles = 0, zz_run = 0, zz_max = 0;

    function automatic vec_t mk(logic ce, logic we, logic oe, logic zz, logic dqoe,
                                logic [1:0] bs, logic [19:0] a, logic [15:0] d, logic dn);
        return {ce, we, oe, zz, dqoe, bs, a, d, dn};
    endfunction

    function automatic vec_t idle_v(logic dn);
        return mk(1, 1, 1, 1, 0, 2'b11, 20'h0, 16'h0, dn);
    endfunction

    // R1, R2, R7: expected word from the requirement text
    function automatic logic [19:0] calc_word(logic pg, logic [1:0] t, logic sp,
                                              logic [2:0] ar, logic sw);
        logic [1:0] tc;
        case (t)
            2'd3: tc = 2'b00;
            2'd2: tc = 2'b01;
            2'd1: tc = 2'b10;
            default: tc = 2'b11;
        endcase
        return {12'h0, pg, tc, (sw ? 1'b1 : sp), 1'b0, ar};
    endfunction

    task automatic push(vec_t v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic push_sleep(logic [19:0] w);
        for (int i = 0; i < LEAD; i++) push(mk(1, 1, 1, 0, 0, 2'b11, w, 16'h0, 0), "R4");
        for (int i = 0; i < ACC;  i++) push(mk(0, 0, 1, 0, 0, 2'b11, w, 16'h0, 0), "R1");
        for (int i = 0; i < HOLD; i++) push(mk(1, 1, 1, 0, 0, 2'b11, w, 16'h0, 0), "R4");
        push(idle_v(1), "R9");
    endtask

    task automatic push_sw(logic [19:0] w);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < GAP; i++) push(mk(1, 1, 1, 1, 0, 2'b11, 20'hFFFFF, 16'h0, 0), "R6");
            for (int i = 0; i < ACC; i++) begin
                if (k < 2)       push(mk(0, 1, 0, 1, 0, 2'b00, 20'hFFFFF, 16'h0, 0), "R6");
                else if (k == 2) push(mk(0, 0, 1, 1, 1, 2'b00, 20'hFFFFF, 16'h0, 0), "R6");
                else             push(mk(0, 0, 1, 1, 1, 2'b00, 20'hFFFFF, w[15:0], 0), "R7");
            end
        end
        push(idle_v(1), "R9");
    endtask

    task automatic check(string t, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", t, act, expv, cycles);
        end
    endtask

    // per-cycle reference comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            vec_t  ev;
            vec_t  obs;
            string t;
            logic  eb;
            cycles++;
            if (mem_sleep_n === 1'b0) zz_run++; else zz_run = 0;
            if (zz_run > zz_max) zz_max = zz_run;
            obs = {mem_ce_n, mem_we_n, mem_oe_n, mem_sleep_n, mem_dq_oe, mem_bsel_n,
                   mem_addr, mem_dq_out, done};
            eb = (exp_q.size() > 0);
            if (exp_q.size() > 0 && (grant || exp_q[0][0])) begin
                ev = exp_q.pop_front();
                t  = tag_q.pop_front();
                if (!grant) ev = idle_v(ev[0]);
            end else begin
                ev = idle_v(0);
                t  = eb ? "R8" : "R10";
            end
            check(t, {18'h0, obs, busy, reject}, {18'h0, ev, eb, exp_reject});
            if (cycles > 100000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    task automatic run_load(logic sw, logic pg, logic [1:0] t, logic sp,
                            logic [2:0] ar, logic [1:0] ct);
        @(posedge clk); #1;
        use_sw = sw; page_en = pg; temp_sel = t; sleep_par = sp; array_sel = ar;
        case_temp = ct; start = 1;
        @(posedge clk); #1;
        start = 0;
        if (t < ct) begin
            exp_reject = 1;
            push(idle_v(1), "R3");
        end else begin
            exp_reject = 0;
            if (sw) push_sw(calc_word(pg, t, sp, ar, sw));
            else    push_sleep(calc_word(pg, t, sp, ar, sw));
        end
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #2;
        // R10: reset state while reset is held
        check("R10", {mem_ce_n, mem_we_n, mem_oe_n, mem_sleep_n, mem_dq_oe, busy, done, reject},
              {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        repeat (3) @(posedge clk);

        // R4, R1, R2: sleep-pin method, +85 C, deep power-down, none of array -> 0x84
        run_load(0, 1, 2'd3, 0, 3'b100, 2'd0);
        wait_empty();
        // R2, R7: sleep-pin method, +45 C, partial array kept -> 0x51
        run_load(0, 0, 2'd1, 1, 3'b001, 2'd1);
        wait_empty();
        // R6, R7: unlock pattern, sleep_par=0 forced to 1 -> 0xB2
        run_load(1, 1, 2'd2, 0, 3'b010, 2'd2);
        wait_empty();
        // R3: +15 C request under a +70 C case class is refused
        run_load(0, 1, 2'd0, 1, 3'b000, 2'd2);
        wait_empty();
        // R3 cleared by next accepted load; R2 boundary equal classes -> 0x70
        run_load(0, 0, 2'd0, 1, 3'b000, 2'd0);
        wait_empty();

        // R8, R9: grant withdrawn periodically, stray start while busy
        run_load(1, 0, 2'd3, 1, 3'b011, 2'd1);
        for (int i = 0; exp_q.size() != 0; i++) begin
            grant = ((i % 4) != 2);
            start = (i == 5);
            @(posedge clk); #1;
        end
        grant = 1;
        start = 0;
        // R9: stray start must not launch a second load
        repeat (4) @(posedge clk);

        // R8: sleep-pin method with grant gaps
        run_load(0, 1, 2'd2, 0, 3'b110, 2'd0);
        for (int i = 0; exp_q.size() != 0; i++) begin
            grant = ((i % 3) != 1);
            @(posedge clk); #1;
        end
        grant = 1;
        repeat (3) @(posedge clk);

        // R5: longest sleep-pin low run within the window
        check("R5", 64'(zz_max <= MAXZ), 64'd1);
        // R11 covered by the per-cycle compare (read and write vectors never overlap)
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule